// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block keeps a 64-bit supervisor timer-compare value behind a CSR access port and compares it, unsigned, against a free-running 64-bit time input. When time has reached or passed the stored value, a supervisor timer-pending output goes high. That output is combined with two enable inputs to form an interrupt request. The core's trap logic takes this request and applies its own delegation rules.

The compare value is always 64 bits wide, whatever the data-path width is. On a 64-bit build the whole value sits at CSR address 0x14D. On a 32-bit build, address 0x14D carries bits 31:0 and address 0x15D carries bits 63:32. Software writes the two halves separately and has to cope with the mixed value that exists between the two writes.

Each access is checked against the requester's privilege level and against the build option that says whether the feature is present. A refused access raises an illegal-instruction flag in the same cycle and changes nothing. The pending output comes from a registered comparison, so it follows a register write or a change of time one clock later.

Top module: `stc_timer_unit`

## Requirements
- R1: On a 64-bit build (XLEN=64), a legal write at address 0x14D replaces all 64 compare bits, and a read at 0x14D returns all 64. Address 0x15D is not a compare address on this build.
- R2: On a 32-bit build (XLEN=32), address 0x14D reads and writes compare bits 31:0, and address 0x15D reads and writes compare bits 63:32.
- R3: A write to one 32-bit half leaves the other half unchanged.
- R4: The pending output stip_o is high in the cycle after a clock edge at which time_i >= compare (unsigned 64-bit). The comparison is registered, so stip_o lags a write or a change of time_i by one clock.
- R5: stip_o is a level and is not latched. Once the compare value exceeds time_i, stip_o is low from the next clock on. No CSR write sets stip_o directly.
- R6: csr_rdata_o returns the selected compare bits in the same cycle that csr_valid_i is high, provided the access is legal and hits a compare address. Otherwise csr_rdata_o is zero. A write also returns the value held before that write.
- R7: csr_illegal_o is high in the same cycle as an access to a compare address in either of two cases: the privilege is below supervisor (encoding 00 = user; 01 = supervisor, and 10 and 11 count as at or above supervisor), or the build has PRESENT=0. The compare register is left unchanged.
- R8: After reset the compare register holds all ones and stip_o is low.
- R9: irq_o = stip_o AND stie_i AND sie_i.
- R10: An access to any other address raises no illegal flag, returns zero and leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_valid_i | input | 1 | CSR access strobe |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | ADDR_W | CSR address |
| csr_wdata_i | input | XLEN | Write data |
| csr_priv_i | input | 2 | Privilege of the requester (00 U, 01 S, 11 M) |
| csr_rdata_o | output | XLEN | Read data, same cycle |
| csr_illegal_o | output | 1 | Illegal-instruction flag, same cycle |
| time_i | input | 64 | Free-running time value |
| stie_i | input | 1 | Supervisor timer-interrupt enable |
| sie_i | input | 1 | Global supervisor-interrupt enable |
| stip_o | output | 1 | Supervisor timer pending |
| irq_o | output | 1 | Gated interrupt request |

## Verification
A compare-register write and a crossing of time over the old compare value can land on the same clock edge. The bench provokes this by moving time_i onto the old value at the same edge that a write raises the value above time. It then expects stip_o high for exactly one cycle, followed by low. It also lands a refused user-level write on a time crossing, and expects the pending bit to rise while the register stays as it was.

// File: rtl/stc_pkg.sv
package stc_pkg;
    localparam int unsigned CMP_W = 64;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    typedef struct packed {
        logic [CMP_W-1:0] cmp;
        logic             pend;
    } store_t;
endpackage

// File: rtl/stc_access.sv
module stc_access #(
    parameter int unsigned       XLEN    = 32,
    parameter int unsigned       ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] LO_ADDR = 12'h14D,
    parameter logic [ADDR_W-1:0] HI_ADDR = 12'h15D,
    parameter bit                PRESENT = 1'b1
) (
    input  logic                      valid_i,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [XLEN-1:0]           wdata_i,
    input  logic [1:0]                priv_i,
    input  logic [stc_pkg::CMP_W-1:0] cmp_i,
    output logic [XLEN-1:0]           rdata_o,
    output logic                      illegal_o,
    output logic                      wr_lo_o,
    output logic                      wr_hi_o,
    output logic [XLEN-1:0]           wr_data_o
);
    localparam int unsigned CMP_W     = stc_pkg::CMP_W;
    localparam logic [1:0]  MIN_LEVEL = stc_pkg::PRIV_S;

    logic            sel_lo;
    logic            sel_hi;
    logic            hit;
    logic            legal;
    logic [XLEN-1:0] rd_sel;

    generate
        if (XLEN == CMP_W) begin : g_full
            assign sel_lo = (addr_i == LO_ADDR);
            assign sel_hi = 1'b0;
            assign rd_sel = cmp_i[XLEN-1:0];
        end else begin : g_split
            assign sel_lo = (addr_i == LO_ADDR);
            assign sel_hi = (addr_i == HI_ADDR);
            assign rd_sel = sel_hi ? cmp_i[CMP_W-1 -: XLEN] : cmp_i[XLEN-1:0];
        end
    endgenerate

    always_comb begin
        hit       = valid_i && (sel_lo || sel_hi);
        legal     = PRESENT && (priv_i >= MIN_LEVEL);
        illegal_o = hit && !legal;
        wr_lo_o   = hit && legal && we_i && sel_lo;
        wr_hi_o   = hit && legal && we_i && sel_hi;
        wr_data_o = wdata_i;
        rdata_o   = (hit && legal) ? rd_sel : '0;
    end
endmodule

// File: rtl/stc_store.sv
module stc_store #(
    parameter int unsigned XLEN = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_lo_i,
    input  logic                      wr_hi_i,
    input  logic [XLEN-1:0]           wr_data_i,
    input  logic [stc_pkg::CMP_W-1:0] time_i,
    output logic [stc_pkg::CMP_W-1:0] cmp_o,
    output logic                      pend_o
);
    localparam int unsigned CMP_W = stc_pkg::CMP_W;
    localparam int unsigned HALF  = CMP_W / 2;

    stc_pkg::store_t st_d, st_q;
    logic [CMP_W-1:0] wr_mask;
    logic [CMP_W-1:0] wr_val;

    generate
        if (XLEN == CMP_W) begin : g_full
            assign wr_mask = {CMP_W{wr_lo_i}};
            assign wr_val  = wr_data_i;
        end else begin : g_split
            assign wr_mask = {{HALF{wr_hi_i}}, {HALF{wr_lo_i}}};
            assign wr_val  = {wr_data_i, wr_data_i};

            AST_HALF_KEEP_HI: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_lo_i && !wr_hi_i) |=> $stable(st_q.cmp[CMP_W-1:HALF])); // R3
            AST_HALF_KEEP_LO: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_hi_i && !wr_lo_i) |=> $stable(st_q.cmp[HALF-1:0])); // R3
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.cmp  = (st_q.cmp & ~wr_mask) | (wr_val & wr_mask);
        st_d.pend = (time_i >= st_q.cmp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmp  <= '1;
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_o  = st_q.cmp;
    assign pend_o = st_q.pend;

    AST_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (time_i >= cmp_o) |=> pend_o); // R4
    AST_PEND_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (time_i < cmp_o) |=> !pend_o); // R5
    AST_RESET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((&cmp_o) && !pend_o)); // R8
endmodule

// File: rtl/stc_irq_gate.sv
module stc_irq_gate (
    input  logic pend_i,
    input  logic stie_i,
    input  logic sie_i,
    output logic irq_o
);
    always_comb begin
        irq_o = pend_i && stie_i && sie_i;
    end
endmodule

// File: rtl/stc_timer_unit.sv
module stc_timer_unit #(
    parameter int unsigned       XLEN    = 32,
    parameter int unsigned       ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] LO_ADDR = 12'h14D,
    parameter logic [ADDR_W-1:0] HI_ADDR = 12'h15D,
    parameter bit                PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_valid_i,
    input  logic              csr_we_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    input  logic [1:0]        csr_priv_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              csr_illegal_o,
    input  logic [63:0]       time_i,
    input  logic              stie_i,
    input  logic              sie_i,
    output logic              stip_o,
    output logic              irq_o
);
    localparam int unsigned CMP_W = stc_pkg::CMP_W;

    logic             wr_lo;
    logic             wr_hi;
    logic [XLEN-1:0]  wr_data;
    logic [CMP_W-1:0] cmp_val;
    logic             foreign;

    stc_access #(
        .XLEN(XLEN), .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR),
        .HI_ADDR(HI_ADDR), .PRESENT(PRESENT)
    ) u_access (
        .valid_i   (csr_valid_i),
        .we_i      (csr_we_i),
        .addr_i    (csr_addr_i),
        .wdata_i   (csr_wdata_i),
        .priv_i    (csr_priv_i),
        .cmp_i     (cmp_val),
        .rdata_o   (csr_rdata_o),
        .illegal_o (csr_illegal_o),
        .wr_lo_o   (wr_lo),
        .wr_hi_o   (wr_hi),
        .wr_data_o (wr_data)
    );

    stc_store #(.XLEN(XLEN)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo_i   (wr_lo),
        .wr_hi_i   (wr_hi),
        .wr_data_i (wr_data),
        .time_i    (time_i),
        .cmp_o     (cmp_val),
        .pend_o    (stip_o)
    );

    stc_irq_gate u_gate (
        .pend_i (stip_o),
        .stie_i (stie_i),
        .sie_i  (sie_i),
        .irq_o  (irq_o)
    );

    assign foreign = (csr_addr_i != LO_ADDR) && ((XLEN == CMP_W) || (csr_addr_i != HI_ADDR));

    AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal_o |=> $stable(cmp_val)); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stip_o && stie_i && sie_i)); // R9
    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid_i && foreign) |-> (!csr_illegal_o && (csr_rdata_o == '0))); // R10
    AST_FOREIGN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid_i && foreign) |=> $stable(cmp_val)); // R10
endmodule

// File: tb/stc_timer_unit_test.sv
`timescale 1ns/1ps
module stc_timer_unit_test;
    localparam logic [11:0] A_LO = 12'h14D;
    localparam logic [11:0] A_HI = 12'h15D;
    localparam logic [11:0] A_XX = 12'h140;
    localparam logic [1:0]  PU = 2'b00, PS = 2'b01, PM = 2'b11;

    // {time, compare, expected pending}
    localparam logic [128:0] VEC [8] = '{
        {64'd100, 64'd100, 1'b1},
        {64'd99, 64'd100, 1'b0},
        {64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF, 1'b1},
        {64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0000, 1'b0},
        {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1},
        {64'd5, 64'hFFFF_FFFF_0000_0000, 1'b0},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
        {64'd0, 64'd0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csr_valid = 1'b0, csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [1:0]  csr_priv = 2'b01;
    logic [63:0] tnow = '0;
    logic stie = 1'b1, sie = 1'b1;
    logic [31:0] rdata, n_rdata;
    logic illegal, stip, irq, n_illegal, n_stip, n_irq;
    logic w_valid = 1'b0, w_we = 1'b0;
    logic [11:0] w_addr = '0;
    logic [63:0] w_wdata = '0;
    logic [63:0] w_rdata;
    logic w_illegal, w_stip, w_irq;

    int nchk = 0;
    int nfail = 0;
    logic [31:0] cap_rd, cap_nrd;
    logic cap_il, cap_nil;
    logic [63:0] w_cap_rd;
    logic w_cap_il;

    always #5 clk = ~clk;

    stc_timer_unit #(.XLEN(32)) uut (
        .clk(clk), .rst_n(rst_n), .csr_valid_i(csr_valid), .csr_we_i(csr_we),
        .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata), .csr_priv_i(csr_priv),
        .csr_rdata_o(rdata), .csr_illegal_o(illegal), .time_i(tnow),
        .stie_i(stie), .sie_i(sie), .stip_o(stip), .irq_o(irq));

    stc_timer_unit #(.XLEN(32), .PRESENT(1'b0)) uut_na (
        .clk(clk), .rst_n(rst_n), .csr_valid_i(csr_valid), .csr_we_i(csr_we),
        .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata), .csr_priv_i(csr_priv),
        .csr_rdata_o(n_rdata), .csr_illegal_o(n_illegal), .time_i(tnow),
        .stie_i(stie), .sie_i(sie), .stip_o(n_stip), .irq_o(n_irq));

    stc_timer_unit #(.XLEN(64)) uut64 (
        .clk(clk), .rst_n(rst_n), .csr_valid_i(w_valid), .csr_we_i(w_we),
        .csr_addr_i(w_addr), .csr_wdata_i(w_wdata), .csr_priv_i(csr_priv),
        .csr_rdata_o(w_rdata), .csr_illegal_o(w_illegal), .time_i(tnow),
        .stie_i(stie), .sie_i(sie), .stip_o(w_stip), .irq_o(w_irq));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op32(input logic we, input logic [11:0] a, input logic [31:0] d, input logic [1:0] p);
        @(negedge clk);
        csr_valid = 1'b1; csr_we = we; csr_addr = a; csr_wdata = d; csr_priv = p;
        #1;
        cap_rd = rdata; cap_il = illegal; cap_nrd = n_rdata; cap_nil = n_illegal;
        @(negedge clk);
        csr_valid = 1'b0; csr_we = 1'b0; csr_priv = PS;
    endtask

    task automatic op64(input logic we, input logic [11:0] a, input logic [63:0] d, input logic [1:0] p);
        @(negedge clk);
        w_valid = 1'b1; w_we = we; w_addr = a; w_wdata = d; csr_priv = p;
        #1;
        w_cap_rd = w_rdata; w_cap_il = w_illegal;
        @(negedge clk);
        w_valid = 1'b0; w_we = 1'b0; csr_priv = PS;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        #1000000;
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [63:0] t, c;
        logic e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset stip", {63'd0, stip}, 64'd0);
        chk("R8 reset irq", {63'd0, irq}, 64'd0);
        op32(1'b0, A_LO, '0, PS);
        chk("R8 reset low half", {32'd0, cap_rd}, 64'hFFFF_FFFF);
        op32(1'b0, A_HI, '0, PS);
        chk("R8 reset high half", {32'd0, cap_rd}, 64'hFFFF_FFFF);
        op64(1'b0, A_LO, '0, PS);
        chk("R8 reset 64-bit", w_cap_rd, 64'hFFFF_FFFF_FFFF_FFFF);

        for (int i = 0; i < 8; i++) begin
            t = VEC[i][128:65]; c = VEC[i][64:1]; e = VEC[i][0];
            tnow = t;
            op32(1'b1, A_LO, c[31:0], PS);
            op32(1'b1, A_HI, c[63:32], PM);
            op64(1'b1, A_LO, c, PS);
            @(negedge clk);
            chk($sformatf("R4 R2 vec%0d stip", i), {63'd0, stip}, {63'd0, e});
            chk($sformatf("R1 vec%0d stip64", i), {63'd0, w_stip}, {63'd0, e});
            chk($sformatf("R9 vec%0d irq", i), {63'd0, irq}, {63'd0, e});
            op32(1'b0, A_LO, '0, PS);
            chk($sformatf("R2 R6 vec%0d low", i), {32'd0, cap_rd}, {32'd0, c[31:0]});
            op32(1'b0, A_HI, '0, PS);
            chk($sformatf("R2 R6 vec%0d high", i), {32'd0, cap_rd}, {32'd0, c[63:32]});
            op64(1'b0, A_LO, '0, PS);
            chk($sformatf("R1 vec%0d read64", i), w_cap_rd, c);
        end

        // R3: half write keeps the other half
        op32(1'b1, A_LO, 32'h1111_2222, PS);
        op32(1'b1, A_HI, 32'h0000_0033, PS);
        op32(1'b1, A_LO, 32'h0000_1234, PS);
        chk("R6 write returns old value", {32'd0, cap_rd}, 64'h1111_2222);
        op32(1'b0, A_HI, '0, PS);
        chk("R3 high kept", {32'd0, cap_rd}, 64'h33);
        op32(1'b1, A_HI, 32'h0000_0044, PS);
        op32(1'b0, A_LO, '0, PS);
        chk("R3 low kept", {32'd0, cap_rd}, 64'h1234);

        // R4 lag on a rising time
        op32(1'b1, A_HI, 32'd0, PS);
        op32(1'b1, A_LO, 32'd200, PS);
        tnow = 64'd199;
        repeat (2) @(negedge clk);
        chk("R4 below compare", {63'd0, stip}, 64'd0);
        tnow = 64'd200;
        #1;
        chk("R4 one-cycle lag", {63'd0, stip}, 64'd0);
        @(negedge clk);
        chk("R4 set after lag", {63'd0, stip}, 64'd1);

        // R5 clearing write: old level survives one cycle
        op32(1'b1, A_LO, 32'd900, PS);
        chk("R5 old level during lag", {63'd0, stip}, 64'd1);
        @(negedge clk);
        chk("R5 cleared", {63'd0, stip}, 64'd0);

        // same edge: time reaches old compare while write raises it
        op32(1'b1, A_LO, 32'd300, PS);
        tnow = 64'd299;
        @(negedge clk);
        @(negedge clk);
        tnow = 64'd300;
        csr_valid = 1'b1; csr_we = 1'b1; csr_addr = A_LO; csr_wdata = 32'd500;
        @(negedge clk);
        csr_valid = 1'b0; csr_we = 1'b0;
        chk("R5 spurious pulse high", {63'd0, stip}, 64'd1);
        @(negedge clk);
        chk("R5 spurious pulse gone", {63'd0, stip}, 64'd0);

        // R7: user-level write on a time crossing
        tnow = 64'd500;
        op32(1'b1, A_LO, 32'd1000, PU);
        chk("R7 user illegal", {63'd0, cap_il}, 64'd1);
        chk("R7 user rdata zero", {32'd0, cap_rd}, 64'd0);
        chk("R7 pend still rises", {63'd0, stip}, 64'd1);
        op32(1'b0, A_LO, '0, PS);
        chk("R7 register unchanged", {32'd0, cap_rd}, 64'd500);
        chk("R7 absent build illegal", {63'd0, cap_nil}, 64'd1);
        chk("R7 absent build rdata", {32'd0, cap_nrd}, 64'd0);
        op32(1'b0, A_HI, '0, PM);
        chk("R7 machine legal", {63'd0, cap_il}, 64'd0);
        op64(1'b1, A_LO, 64'd7, PU);
        chk("R7 user illegal 64", {63'd0, w_cap_il}, 64'd1);

        // R9 gating
        stie = 1'b0; #1;
        chk("R9 stie off", {63'd0, irq}, 64'd0);
        stie = 1'b1; sie = 1'b0; #1;
        chk("R9 sie off", {63'd0, irq}, 64'd0);
        sie = 1'b1; #1;
        chk("R9 both on", {63'd0, irq}, 64'd1);

        // R10 foreign addresses
        op32(1'b1, A_XX, 32'd1, PS);
        chk("R10 no illegal", {63'd0, cap_il}, 64'd0);
        chk("R10 rdata zero", {32'd0, cap_rd}, 64'd0);
        op32(1'b0, A_LO, '0, PS);
        chk("R10 register kept", {32'd0, cap_rd}, 64'd500);
        op64(1'b1, A_HI, 64'd3, PS);
        chk("R10 R1 high addr not mapped 64", {63'd0, w_cap_il}, 64'd0);
        chk("R10 R1 high addr rdata 64", w_cap_rd, 64'd0);
        op64(1'b0, A_LO, '0, PS);
        chk("R1 64-bit value kept", w_cap_rd, 64'd0);

        summary();
    end
endmodule